// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the serial test port of a memory device. A 16-state controller, steered by the mode-select input sampled on each rising test-clock edge, places one of four shift registers between the serial data input and the serial data output. The four registers are a 3-bit instruction register, a 1-bit bypass stage, a 32-bit identification word and a boundary register whose length is a parameter. The port has no dedicated reset pin. Power-on reset, or enough consecutive mode-select ones, returns it to its reset state with the identification instruction active.

The boundary register captures the device's pin values in parallel. Positions that no pin backs capture a constant one. Values shifted into the boundary register move to a parallel output on Update-DR, and an external-test flag tells the pad ring to drive them. A separate flag tells every device output to float. The serial output changes only on falling test-clock edges and is enabled only while a register is shifting.

Top module: `scan_tap`

## Requirements
- R1: Power-on reset (por_n low) places the controller in Test-Logic-Reset. From any state, five consecutive rising tck edges with tms high also reach Test-Logic-Reset.
- R2: tms and tdi are sampled on rising tck edges. tdo changes only on falling tck edges and holds its value across the rising edge that shifts.
- R3: tdo_oe is high exactly while the controller is in Shift-IR or Shift-DR, as seen after the falling edge that follows entry into the state. It is low in every other state, including Pause and Exit states.
- R4: Capture-IR loads the instruction shift register with 3'b001. The instruction shifts least significant bit first, so the first three bits out are 1, 0, 0.
- R5: A newly shifted instruction changes the active instruction only on entry to Update-IR. While the controller waits in Pause-IR or Exit-IR, the previous instruction stays in force.
- R6: The active instruction is IDCODE (3'b001) after power-on reset and whenever Test-Logic-Reset is entered.
- R7: Under IDCODE, Capture-DR loads the 32-bit parameter ID_CODE with bit 0 forced to 1. Bit 0 is the first bit out on tdo.
- R8: Instruction decode: 3'b000 external test, 3'b001 identification, 3'b010 float-outputs sample and 3'b100 sample/preload. The codes 3'b011, 3'b101, 3'b110 and 3'b111 select the bypass stage. The bypass stage captures 0, so the data path shows a one-bit delay.
- R9: While 3'b010 is the active instruction, hiz_force is high and the boundary register is the selected data register. For every other instruction, hiz_force is low.
- R10: Under 3'b000, 3'b010 or 3'b100, Capture-DR loads boundary bit i from pin_vals[i] where PIN_MASK[i] is 1, and with 1 where PIN_MASK[i] is 0. Boundary bit 0 is shifted out first.
- R11: Under 3'b000 or 3'b100, entry to Update-DR copies the boundary shift register to bsr_drive. Under any other instruction, bsr_drive is unchanged. ext_drive is high exactly while 3'b000 is active. bsr_drive resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in, sampled on rising tck |
| pin_vals | input | BSR_LEN | Pin values captured into the boundary register |
| tdo | output | 1 | Serial data out, changes on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| hiz_force | output | 1 | Forces all device outputs to high impedance |
| ext_drive | output | 1 | Pad ring drives bsr_drive onto the pins |
| bsr_drive | output | BSR_LEN | Boundary values latched at Update-DR |

## Verification
A bit captured at Capture-DR or Capture-IR reaches tdo at the falling edge half a cycle after the controller enters the Shift state. Each later bit follows one full cycle after the one before it. The bench therefore samples tdo 2 ns after every falling edge, before driving the next tms/tdi. It checks 2 ns after the following rising edge that tdo has not moved. hiz_force, ext_drive and bsr_drive change at the rising edge that enters Update-IR, Update-DR or Test-Logic-Reset, so the bench samples them after the controller has moved on to the next state. An exhaustive sweep over all eight instruction codes, with two pin patterns each, compares every serial output stream with a value computed from the code's register length and capture value.

// File: rtl/scan_tap_pkg.sv
package scan_tap_pkg;

  localparam int IR_W = 3;
  localparam int ID_W = 32;

  typedef enum logic [3:0] {
    ST_TLR, ST_RTI,
    ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
    ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {SEL_BYP, SEL_ID, SEL_BSR} dr_sel_e;

  localparam logic [IR_W-1:0] OP_EXTEST  = 3'b000;
  localparam logic [IR_W-1:0] OP_IDCODE  = 3'b001;
  localparam logic [IR_W-1:0] OP_SAMPZ   = 3'b010;
  localparam logic [IR_W-1:0] OP_SAMPLE  = 3'b100;
  localparam logic [IR_W-1:0] IR_CAPTURE = 3'b001;

  function automatic tap_state_e tap_next(input tap_state_e s, input logic tms);
    case (s)
      ST_TLR:    return tms ? ST_TLR    : ST_RTI;
      ST_RTI:    return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_DR: return tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: return tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  return tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: return tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: return tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: return tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: return tms ? ST_SEL_DR : ST_RTI;
      ST_SEL_IR: return tms ? ST_TLR    : ST_CAP_IR;
      ST_CAP_IR: return tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  return tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: return tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: return tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: return tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: return tms ? ST_SEL_DR : ST_RTI;
      default:   return ST_TLR;
    endcase
  endfunction

  function automatic dr_sel_e op_select(input logic [IR_W-1:0] op);
    case (op)
      OP_EXTEST, OP_SAMPZ, OP_SAMPLE: return SEL_BSR;
      OP_IDCODE:                      return SEL_ID;
      default:                        return SEL_BYP;
    endcase
  endfunction

  function automatic logic op_updates_bsr(input logic [IR_W-1:0] op);
    return (op == OP_EXTEST) || (op == OP_SAMPLE);
  endfunction

  function automatic logic [ID_W-1:0] id_word(input logic [ID_W-1:0] raw);
    return {raw[ID_W-1:1], 1'b1};
  endfunction

endpackage

// File: rtl/scan_tap_fsm.sv
module scan_tap_fsm
  import scan_tap_pkg::*;
(
  input  logic       tck,
  input  logic       por_n,
  input  logic       tms,
  output tap_state_e state_q,
  output tap_state_e state_d
);

  always_comb state_d = tap_next(state_q, tms);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) state_q <= ST_TLR;
    else        state_q <= state_d;
  end

endmodule

// File: rtl/scan_tap_ir.sv
module scan_tap_ir
  import scan_tap_pkg::*;
(
  input  logic            tck,
  input  logic            por_n,
  input  logic            tdi,
  input  tap_state_e      state_q,
  input  tap_state_e      state_d,
  output logic [IR_W-1:0] ir_q,
  output logic [IR_W-1:0] ir_sr
);

  logic ir_capture_ev, ir_shift_ev, ir_update_ev, tlr_enter_ev;

  assign ir_capture_ev = (state_q == ST_CAP_IR);
  assign ir_shift_ev   = (state_q == ST_SH_IR);
  assign ir_update_ev  = (state_d == ST_UPD_IR);
  assign tlr_enter_ev  = (state_d == ST_TLR);

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)             ir_sr <= IR_CAPTURE;
    else if (ir_capture_ev) ir_sr <= IR_CAPTURE;
    else if (ir_shift_ev)   ir_sr <= {tdi, ir_sr[IR_W-1:1]};
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)            ir_q <= OP_IDCODE;
    else if (tlr_enter_ev) ir_q <= OP_IDCODE;
    else if (ir_update_ev) ir_q <= ir_sr;
  end

endmodule

// File: rtl/scan_tap_dr.sv
module scan_tap_dr
  import scan_tap_pkg::*;
#(
  parameter int                  BSR_LEN  = 16,
  parameter logic [BSR_LEN-1:0]  PIN_MASK = 16'h0FFF,
  parameter logic [ID_W-1:0]     ID_CODE  = 32'h0F00_A0D6
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tdi,
  input  tap_state_e         state_q,
  input  tap_state_e         state_d,
  input  logic [IR_W-1:0]    ir_q,
  input  logic [BSR_LEN-1:0] pin_vals,
  output logic               dr_tdo,
  output logic [BSR_LEN-1:0] bsr_upd
);

  localparam logic [ID_W-1:0] ID_VALUE = id_word(ID_CODE);

  dr_sel_e            sel;
  logic               dr_capture_ev, dr_shift_ev, dr_update_ev;
  logic               byp_q;
  logic [ID_W-1:0]    id_sr;
  logic [BSR_LEN-1:0] bsr_sr, cap_val;

  assign sel           = op_select(ir_q);
  assign dr_capture_ev = (state_q == ST_CAP_DR);
  assign dr_shift_ev   = (state_q == ST_SH_DR);
  assign dr_update_ev  = (state_d == ST_UPD_DR) && op_updates_bsr(ir_q);

  for (genvar i = 0; i < BSR_LEN; i++) begin : g_cap
    if (PIN_MASK[i]) begin : g_pin
      assign cap_val[i] = pin_vals[i];
    end else begin : g_fill
      assign cap_val[i] = 1'b1;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) byp_q <= 1'b0;
    else if (sel == SEL_BYP) begin
      if (dr_capture_ev)    byp_q <= 1'b0;
      else if (dr_shift_ev) byp_q <= tdi;
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) id_sr <= ID_VALUE;
    else if (sel == SEL_ID) begin
      if (dr_capture_ev)    id_sr <= ID_VALUE;
      else if (dr_shift_ev) id_sr <= {tdi, id_sr[ID_W-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n) bsr_sr <= '1;
    else if (sel == SEL_BSR) begin
      if (dr_capture_ev)    bsr_sr <= cap_val;
      else if (dr_shift_ev) bsr_sr <= {tdi, bsr_sr[BSR_LEN-1:1]};
    end
  end

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)            bsr_upd <= '0;
    else if (dr_update_ev) bsr_upd <= bsr_sr;
  end

  always_comb begin
    case (sel)
      SEL_ID:  dr_tdo = id_sr[0];
      SEL_BSR: dr_tdo = bsr_sr[0];
      default: dr_tdo = byp_q;
    endcase
  end

endmodule

// File: rtl/scan_tap.sv
module scan_tap
  import scan_tap_pkg::*;
#(
  parameter int                 BSR_LEN  = 16,
  parameter logic [BSR_LEN-1:0] PIN_MASK = 16'h0FFF,
  parameter logic [ID_W-1:0]    ID_CODE  = 32'h0F00_A0D6
) (
  input  logic               tck,
  input  logic               por_n,
  input  logic               tms,
  input  logic               tdi,
  input  logic [BSR_LEN-1:0] pin_vals,
  output logic               tdo,
  output logic               tdo_oe,
  output logic               hiz_force,
  output logic               ext_drive,
  output logic [BSR_LEN-1:0] bsr_drive
);

  tap_state_e      state_q, state_d;
  logic [IR_W-1:0] ir_q, ir_sr;
  logic            dr_tdo;
  logic            in_shift_ir, in_shift_dr;

  scan_tap_fsm u_fsm (
    .tck(tck), .por_n(por_n), .tms(tms), .state_q(state_q), .state_d(state_d)
  );

  scan_tap_ir u_ir (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state_q(state_q), .state_d(state_d),
    .ir_q(ir_q), .ir_sr(ir_sr)
  );

  scan_tap_dr #(.BSR_LEN(BSR_LEN), .PIN_MASK(PIN_MASK), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .por_n(por_n), .tdi(tdi), .state_q(state_q), .state_d(state_d),
    .ir_q(ir_q), .pin_vals(pin_vals), .dr_tdo(dr_tdo), .bsr_upd(bsr_drive)
  );

  assign in_shift_ir = (state_q == ST_SH_IR);
  assign in_shift_dr = (state_q == ST_SH_DR);

  always_ff @(negedge tck or negedge por_n) begin
    if (!por_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= in_shift_ir || in_shift_dr;
      tdo    <= in_shift_ir ? ir_sr[0] : dr_tdo;
    end
  end

  assign hiz_force = (ir_q == OP_SAMPZ);
  assign ext_drive = (ir_q == OP_EXTEST);

endmodule

module scan_tap_chk
  import scan_tap_pkg::*;
#(
  parameter int BSR_LEN = 16
) (
  input logic               tck,
  input logic               por_n,
  input logic               tms,
  input tap_state_e         state_q,
  input logic [IR_W-1:0]    ir_q,
  input logic [IR_W-1:0]    ir_sr,
  input logic               tdo_oe,
  input logic [BSR_LEN-1:0] bsr_drive
);

  logic [2:0] ones_run;

  always_ff @(posedge tck or negedge por_n) begin
    if (!por_n)      ones_run <= '0;
    else if (!tms)   ones_run <= '0;
    else if (ones_run != 3'd7) ones_run <= ones_run + 3'd1;
  end

  AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (!por_n)
    (ones_run >= 3'd5) |-> (state_q == ST_TLR)); // R1

  AST_TDO_OE_SHIFT_ONLY: assert property (@(posedge tck) disable iff (!por_n)
    tdo_oe == ((state_q == ST_SH_IR) || (state_q == ST_SH_DR))); // R3

  AST_IR_CAPTURE_PATTERN: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == ST_CAP_IR) |=> (ir_sr[1:0] == 2'b01)); // R4

  AST_IR_CHANGES_AT_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(ir_q) |-> ((state_q == ST_UPD_IR) || (state_q == ST_TLR))); // R5

  AST_TLR_HOLDS_IDCODE: assert property (@(posedge tck) disable iff (!por_n)
    (state_q == ST_TLR) |-> (ir_q == OP_IDCODE)); // R6

  AST_DRIVE_CHANGES_AT_UPDATE: assert property (@(posedge tck) disable iff (!por_n)
    !$stable(bsr_drive) |-> (state_q == ST_UPD_DR)); // R11

endmodule

bind scan_tap scan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
  .tck(tck), .por_n(por_n), .tms(tms), .state_q(state_q), .ir_q(ir_q),
  .ir_sr(ir_sr), .tdo_oe(tdo_oe), .bsr_drive(bsr_drive)
);

// File: tb/tb_scan_tap.sv
`timescale 1ns/1ps
module tb_scan_tap;

  localparam int          N     = 16;
  localparam logic [N-1:0] MASK = 16'h0FFF;
  localparam logic [31:0] IDRAW = 32'h0F00_A0D6;
  localparam logic [31:0] IDEXP = 32'h0F00_A0D7;
  localparam logic [63:0] M48   = 64'h0000_FFFF_FFFF_FFFF;

  logic         tck = 1'b0;
  logic         por_n = 1'b0;
  logic         tms = 1'b1;
  logic         tdi = 1'b0;
  logic [N-1:0] pin_vals = '0;
  logic         tdo, tdo_oe, hiz_force, ext_drive;
  logic [N-1:0] bsr_drive;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  done = 0;

  always #5 tck = ~tck;

  scan_tap #(.BSR_LEN(N), .PIN_MASK(MASK), .ID_CODE(IDRAW)) dut (
    .tck(tck), .por_n(por_n), .tms(tms), .tdi(tdi), .pin_vals(pin_vals),
    .tdo(tdo), .tdo_oe(tdo_oe), .hiz_force(hiz_force), .ext_drive(ext_drive),
    .bsr_drive(bsr_drive)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic tms_step(input logic b);
    @(negedge tck); #2; tms = b;
    @(posedge tck);
  endtask

  task automatic load_ir(input logic [2:0] op, input bit finish, output logic [2:0] cap);
    tms_step(1); tms_step(1); tms_step(0); tms_step(0);
    for (int i = 0; i < 3; i++) begin
      @(negedge tck); #2;
      cap[i] = tdo;
      chk(tdo_oe == 1'b1, "R3", "oe in Shift-IR", {63'd0, tdo_oe}, 64'd1);
      tms = (i == 2); tdi = op[i];
      @(posedge tck);
    end
    if (finish) begin tms_step(1); tms_step(0); end
    else        tms_step(0);
  endtask

  task automatic finish_ir();
    tms_step(1); tms_step(1); tms_step(0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
    dout = '0;
    tms_step(1); tms_step(0); tms_step(0);
    for (int i = 0; i < n; i++) begin
      @(negedge tck); #2;
      dout[i] = tdo;
      chk(tdo_oe == 1'b1, "R3", "oe in Shift-DR", {63'd0, tdo_oe}, 64'd1);
      tms = (i == n - 1); tdi = din[i];
      @(posedge tck); #2;
      chk(tdo == dout[i], "R2", "tdo moved at rising edge", {63'd0, tdo}, {63'd0, dout[i]});
    end
    tms_step(1); tms_step(0);
  endtask

  function automatic logic [63:0] exp_stream(input logic [2:0] op, input logic [N-1:0] pins,
                                             input logic [63:0] din);
    logic [63:0] cap;
    cap = {48'd0, (pins & MASK) | ~MASK};
    case (op)
      3'b000, 3'b010, 3'b100: return ((din << N) | cap) & M48;
      3'b001:                 return ((din << 32) | {32'd0, IDEXP}) & M48;
      default:                return (din << 1) & M48;
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge tck);
    if (!done) begin
      n_fail++;
      $display("FAIL R1 watchdog act=hung exp=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0]   cap;
    logic [63:0]  dout, din;
    logic [N-1:0] exp_drv;
    logic [N-1:0] pats [2];
    pats[0] = 16'hA5C3;
    pats[1] = 16'h3C0F;
    exp_drv = '0;

    repeat (3) @(posedge tck);
    #2;
    // R1 R6: reset state
    chk(tdo_oe == 0,   "R3",  "oe in reset",        {63'd0, tdo_oe}, 0);
    chk(hiz_force == 0, "R6", "hiz in reset",       {63'd0, hiz_force}, 0);
    chk(ext_drive == 0, "R6", "ext in reset",       {63'd0, ext_drive}, 0);
    chk(bsr_drive == 0, "R11", "drive in reset",    {48'd0, bsr_drive}, 0);
    @(negedge tck); #2; por_n = 1'b1;
    tms_step(0);

    // R7 R1: identification after power-up
    din = 64'h0000_0000_0000_00B4;
    shift_dr(40, din, dout);
    chk(dout[31:0] == IDEXP, "R7", "ID word after power-up", {32'd0, dout[31:0]}, {32'd0, IDEXP});
    chk(dout[39:32] == din[7:0], "R7", "ID pass-through", {56'd0, dout[39:32]}, {56'd0, din[7:0]});
    @(negedge tck); #2;
    chk(tdo_oe == 0, "R3", "oe in Run-Test/Idle", {63'd0, tdo_oe}, 0);

    // R8 R9 R10 R11 R4: sweep all codes and two pin patterns
    for (int op = 0; op < 8; op++) begin
      for (int p = 0; p < 2; p++) begin
        pin_vals = pats[p];
        load_ir(op[2:0], 1'b1, cap);
        chk(cap == 3'b001, "R4", "Capture-IR pattern", {61'd0, cap}, 64'd1);
        chk(hiz_force == (op == 2), "R9", "hiz_force per code", {63'd0, hiz_force}, {63'd0, (op == 2)});
        chk(ext_drive == (op == 0), "R11", "ext_drive per code", {63'd0, ext_drive}, {63'd0, (op == 0)});
        din = 64'hC3A5_96E1_0F5A_7B2D ^ (64'h0101_0101_1234_5678 * (op * 2 + p + 1));
        shift_dr(48, din, dout);
        chk((dout & M48) == exp_stream(op[2:0], pats[p], din),
            (op == 0 || op == 2 || op == 4) ? "R10" : "R8", "DR stream per code",
            dout & M48, exp_stream(op[2:0], pats[p], din));
        if (op == 0 || op == 4) exp_drv = din[47:32];
        chk(bsr_drive == exp_drv, "R11", "bsr_drive after Update-DR", {48'd0, bsr_drive}, {48'd0, exp_drv});
      end
    end

    // R5: instruction waits for Update-IR
    load_ir(3'b001, 1'b1, cap);
    load_ir(3'b010, 1'b0, cap);
    #2;
    chk(hiz_force == 0, "R5", "hiz before Update-IR", {63'd0, hiz_force}, 0);
    finish_ir();
    #2;
    chk(hiz_force == 1, "R5", "hiz after Update-IR", {63'd0, hiz_force}, 1);

    // R1 R6: five ones from Pause-DR
    tms_step(1); tms_step(0); tms_step(0); tms_step(1); tms_step(0);
    for (int k = 0; k < 5; k++) tms_step(1);
    #2;
    chk(hiz_force == 0, "R1", "reset from Pause-DR", {63'd0, hiz_force}, 0);
    tms_step(0);
    shift_dr(32, 64'd0, dout);
    chk(dout[31:0] == IDEXP, "R6", "IDCODE after TMS reset", {32'd0, dout[31:0]}, {32'd0, IDEXP});

    // R1: five ones from Shift-IR
    load_ir(3'b010, 1'b1, cap);
    tms_step(1); tms_step(1); tms_step(0); tms_step(0);
    for (int k = 0; k < 5; k++) tms_step(1);
    #2;
    chk(hiz_force == 0, "R1", "reset from Shift-IR", {63'd0, hiz_force}, 0);
    chk(bsr_drive == exp_drv, "R11", "drive kept through reset", {48'd0, bsr_drive}, {48'd0, exp_drv});
    tms_step(0);

    // R11: preload then external test
    load_ir(3'b100, 1'b1, cap);
    shift_dr(16, 64'h5A3C, dout);
    chk(bsr_drive == 16'h5A3C, "R11", "preload value", {48'd0, bsr_drive}, 64'h5A3C);
    load_ir(3'b000, 1'b1, cap);
    chk(ext_drive == 1 && bsr_drive == 16'h5A3C, "R11", "external drive",
        {47'd0, ext_drive, bsr_drive}, {47'd0, 1'b1, 16'h5A3C});

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule